// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This unit takes one single-precision floating-point operand and returns the nearest integral value in a chosen direction. The result stays in floating-point format, and the sign of the operand is kept. One of four rounding directions applies to each operand. The direction is held in a small writable control field: software writes it once, and every later operand uses it until the next write. Alongside the value, the unit raises an inexact flag whenever rounding changed the operand.

Each operand arrives with a valid strobe. The rounded value and its flag appear on registered outputs one clock later. While no operand is offered, the outputs keep the last result. Operands that are already integral come out unchanged: those whose magnitude is at least 2^23, zeros, infinities and NaNs. For these the inexact flag stays low.

Top module: `fp_integral_rounder`

## Requirements
- R1: The rounding direction is the 2-bit field last written through `cfg_wdata` while `cfg_we` is high. The encodings are 0 = nearest, 1 = toward zero, 2 = toward plus infinity and 3 = toward minus infinity. A write takes effect for operands offered in later cycles. An operand offered in the cycle of the write uses the previous direction.
- R2: In nearest mode the result is whichever of the floor and the ceiling lies closer to the operand. On an exact tie the result is the even one of the two.
- R3: In toward-zero mode a positive operand yields its floor and a negative operand yields its ceiling, so the magnitude never grows.
- R4: In toward-plus-infinity mode the result is the ceiling of the operand.
- R5: In toward-minus-infinity mode the result is the floor of the operand.
- R6: `res_inexact` is 1 exactly when the result bits differ from the operand bits.
- R7: Some operands pass through bit for bit with `res_inexact` = 0. These are operands with a biased exponent of 150 or more (this includes infinities and NaNs, exponent field bits [30:23]) and both zeros.
- R8: The result sign bit (bit 31) always equals the operand sign bit. A negative operand that rounds to zero gives negative zero (0x80000000).
- R9: `res_valid` is high in the cycle after a cycle with `op_valid` high, and low otherwise. While `res_valid` is low, `res_data` and `res_inexact` hold their last values. Back-to-back operands give back-to-back results.
- R10: After reset, `res_valid`, `res_data` and `res_inexact` are 0 and the direction is nearest (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the direction field |
| cfg_wdata | input | 2 | New rounding direction |
| op_valid | input | 1 | Operand present this cycle |
| op_data | input | 32 | Single-precision operand |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 32 | Rounded single-precision value |
| res_inexact | output | 1 | Rounding changed the value |

## Verification
The bench aims at exact ties: 0.5, 1.5, 2.5 and their negatives, plus a tie just below 2^22 whose increment carries into the exponent. A design that rounds ties away from zero, or loses that carry, returns a wrong integer there. Tiny negative values rounded upward must give negative zero, and a subnormal rounded up must give exactly 1.0; a design that drops the sign or mishandles the hidden bit fails these. Infinity, a NaN, negative zero and values at or above 2^23 are sent to catch any stray change or false inexact flag. A direction write in the same cycle as an operand checks that the old direction is still applied.

// File: rtl/fprnd_pkg.sv
package fprnd_pkg;

    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int FP_W   = 1 + EXP_W + MAN_W;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_UP      = 2'd2,
        RND_DOWN    = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic            valid;
        logic [FP_W-1:0] data;
        logic            inexact;
    } rnd_out_t;

endpackage

// File: rtl/fprnd_ctrl.sv
module fprnd_ctrl
    import fprnd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    output rnd_mode_e         mode
);

    rnd_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (cfg_we) begin
            mode_d = rnd_mode_e'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RND_NEAREST;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (mode == rnd_mode_e'($past(cfg_wdata)))); // R1

endmodule

// File: rtl/fprnd_core.sv
module fprnd_core
    import fprnd_pkg::*;
(
    input  logic [FP_W-1:0] operand,
    input  rnd_mode_e       mode,
    output logic [FP_W-1:0] result,
    output logic            inexact
);

    localparam int SH_W = $clog2(MAN_W + 1);
    localparam logic [EXP_W-1:0] BIAS_E    = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] INT_EXP_E = EXP_W'(int'(BIAS_E) + MAN_W);
    localparam logic [FP_W-2:0]  ONE_MAG   = {BIAS_E, {MAN_W{1'b0}}};
    localparam logic [MAN_W:0]   SIG_ONE   = (MAN_W+1)'(1);

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic [MAN_W:0]   sig;
    logic [SH_W-1:0]  fsh;
    logic [MAN_W:0]   frac_mask;
    logic [MAN_W:0]   below_half;
    logic             frac_nz, half, sticky, lsb, incr;
    logic [FP_W-2:0]  trunc_mag, ulp_mag;

    always_comb begin
        sgn        = operand[FP_W-1];
        ex         = operand[FP_W-2:MAN_W];
        man        = operand[MAN_W-1:0];
        sig        = {(ex != '0), man};
        fsh        = '0;
        frac_mask  = '0;
        below_half = '0;
        frac_nz    = 1'b0;
        half       = 1'b0;
        sticky     = 1'b0;
        lsb        = 1'b0;
        incr       = 1'b0;
        trunc_mag  = operand[FP_W-2:0];
        ulp_mag    = '0;
        result     = operand;
        inexact    = 1'b0;

        if (ex >= INT_EXP_E || (ex == '0 && man == '0)) begin
            // already integral, zero, infinity or NaN
        end else if (ex < BIAS_E) begin
            // magnitude below one: integer part is zero
            frac_nz   = 1'b1;
            trunc_mag = '0;
            half      = (ex == BIAS_E - 1'b1);
            sticky    = (ex != BIAS_E - 1'b1) || (man != '0);
            ulp_mag   = ONE_MAG;
        end else begin
            fsh        = SH_W'(INT_EXP_E - ex);
            frac_mask  = (SIG_ONE << fsh) - SIG_ONE;
            below_half = frac_mask >> 1;
            frac_nz    = |(sig & frac_mask);
            half       = sig[fsh - 1'b1];
            sticky     = |(sig & below_half);
            lsb        = sig[fsh];
            trunc_mag  = {ex, man & ~frac_mask[MAN_W-1:0]};
            ulp_mag    = (FP_W-1)'(SIG_ONE << fsh);
        end

        if (frac_nz) begin
            unique case (mode)
                RND_NEAREST: incr = half && (sticky || lsb);
                RND_ZERO:    incr = 1'b0;
                RND_UP:      incr = !sgn;
                RND_DOWN:    incr = sgn;
                default:     incr = 1'b0;
            endcase
            result  = {sgn, trunc_mag + (incr ? ulp_mag : '0)};
            inexact = 1'b1;
        end
    end

endmodule

// File: rtl/fp_integral_rounder.sv
module fp_integral_rounder
    import fprnd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    input  logic              op_valid,
    input  logic [FP_W-1:0]   op_data,
    output logic              res_valid,
    output logic [FP_W-1:0]   res_data,
    output logic              res_inexact
);

    rnd_mode_e       mode;
    logic [FP_W-1:0] core_res;
    logic            core_inx;
    rnd_out_t        out_d, out_q;

    fprnd_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .mode      (mode)
    );

    fprnd_core i_core (
        .operand (op_data),
        .mode    (mode),
        .result  (core_res),
        .inexact (core_inx)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = op_valid;
        if (op_valid) begin
            out_d.data    = core_res;
            out_d.inexact = core_inx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_valid   = out_q.valid;
    assign res_data    = out_q.data;
    assign res_inexact = out_q.inexact;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(res_data) && $stable(res_inexact))); // R9
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (res_data[FP_W-1] == $past(op_data[FP_W-1]))); // R8
    AST_INEXACT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (res_inexact == (res_data != $past(op_data)))); // R6
    AST_ZERO_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && mode == RND_ZERO) |=> (res_data[FP_W-2:0] <= $past(op_data[FP_W-2:0]))); // R3

endmodule

// File: tb/test_fp_integral_rounder.sv
module test_fp_integral_rounder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wdata = '0;
    logic        op_valid = 1'b0;
    logic [31:0] op_data = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic        res_inexact;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5ns clk = ~clk;

    fp_integral_rounder i_fp_integral_rounder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .op_valid    (op_valid),
        .op_data     (op_data),
        .res_valid   (res_valid),
        .res_data    (res_data),
        .res_inexact (res_inexact)
    );

    // {mode, operand, expected result, expected inexact, requirement tag}
    localparam int NV = 29;
    localparam logic [66:0] VEC [NV] = '{
        {2'd0, 32'h3FC00000, 32'h40000000, 1'b1}, // R2 1.5 -> 2
        {2'd0, 32'h40200000, 32'h40000000, 1'b1}, // R2 2.5 -> 2
        {2'd0, 32'hC0200000, 32'hC0000000, 1'b1}, // R2 -2.5 -> -2
        {2'd0, 32'h3F000000, 32'h00000000, 1'b1}, // R2 0.5 -> 0
        {2'd0, 32'hBF000000, 32'h80000000, 1'b1}, // R8 -0.5 -> -0
        {2'd0, 32'h40300000, 32'h40400000, 1'b1}, // R2 2.75 -> 3
        {2'd0, 32'h3E99999A, 32'h00000000, 1'b1}, // R2 0.3 -> 0
        {2'd0, 32'h4A7FFFFE, 32'h4A800000, 1'b1}, // R2 tie carry
        {2'd0, 32'h3F400000, 32'h3F800000, 1'b1}, // R2 0.75 -> 1
        {2'd0, 32'h40400000, 32'h40400000, 1'b0}, // R6 exact 3.0
        {2'd0, 32'h4B000001, 32'h4B000001, 1'b0}, // R7 large
        {2'd0, 32'h7F800000, 32'h7F800000, 1'b0}, // R7 inf
        {2'd0, 32'h7FC00001, 32'h7FC00001, 1'b0}, // R7 NaN
        {2'd0, 32'h80000000, 32'h80000000, 1'b0}, // R7 -0
        {2'd1, 32'h3FC00000, 32'h3F800000, 1'b1}, // R3
        {2'd1, 32'hBFC00000, 32'hBF800000, 1'b1}, // R3
        {2'd1, 32'hBE99999A, 32'h80000000, 1'b1}, // R3
        {2'd1, 32'h40300000, 32'h40000000, 1'b1}, // R3
        {2'd2, 32'h3FC00000, 32'h40000000, 1'b1}, // R4
        {2'd2, 32'hBFC00000, 32'hBF800000, 1'b1}, // R4
        {2'd2, 32'hBE99999A, 32'h80000000, 1'b1}, // R8
        {2'd2, 32'h3E99999A, 32'h3F800000, 1'b1}, // R4
        {2'd2, 32'h00000001, 32'h3F800000, 1'b1}, // R4 subnormal
        {2'd2, 32'h40000000, 32'h40000000, 1'b0}, // R6
        {2'd3, 32'h3FC00000, 32'h3F800000, 1'b1}, // R5
        {2'd3, 32'hBFC00000, 32'hC0000000, 1'b1}, // R5
        {2'd3, 32'h3E99999A, 32'h00000000, 1'b1}, // R5
        {2'd3, 32'hBE99999A, 32'hBF800000, 1'b1}, // R5
        {2'd3, 32'hC0300000, 32'hC0400000, 1'b1}  // R5
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 res_valid", 32'(res_valid), 32'd0);
        check("R10 res_data", res_data, 32'd0);
        check("R10 res_inexact", 32'(res_inexact), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 direction defaults to nearest: 2.5 -> 2.0
        op_valid = 1'b1;
        op_data  = 32'h40200000;
        @(negedge clk);
        op_valid = 1'b0;
        check("R10 default mode", res_data, 32'h40000000);

        for (int i = 0; i < NV; i++) begin
            cfg_we    = 1'b1;
            cfg_wdata = VEC[i][66:65];
            @(negedge clk);
            cfg_we   = 1'b0;
            op_valid = 1'b1;
            op_data  = VEC[i][64:33];
            @(negedge clk);
            op_valid = 1'b0;
            check($sformatf("R1 vec%0d valid", i), 32'(res_valid), 32'd1);
            check($sformatf("R2-5 vec%0d data", i), res_data, VEC[i][32:1]);
            check($sformatf("R6 vec%0d inexact", i), 32'(res_inexact), 32'(VEC[i][0]));
        end

        // R1: mode write in the same cycle as an operand; direction is 3 here
        cfg_we    = 1'b1;
        cfg_wdata = 2'd0;
        op_valid  = 1'b1;
        op_data   = 32'h3FC00000;
        @(negedge clk);
        cfg_we  = 1'b0;
        op_data = 32'h40200000;
        check("R1 old mode applied", res_data, 32'h3F800000);
        check("R9 valid first", 32'(res_valid), 32'd1);
        @(negedge clk);
        op_valid = 1'b0;
        op_data  = 32'h40300000;
        check("R9 back-to-back data", res_data, 32'h40000000);
        check("R9 back-to-back valid", 32'(res_valid), 32'd1);
        @(negedge clk);
        check("R9 idle valid", 32'(res_valid), 32'd0);
        check("R9 idle hold data", res_data, 32'h40000000);
        check("R9 idle hold inexact", 32'(res_inexact), 32'd1);

        finish_run();
    end

endmodule